// File: doc/BRIEF.md
# Bus Boot-Remap Register Controller

This block is a word-addressed register file for a bus fabric. It publishes the window settings (base address and size code) of up to 32 bus slaves and performs a one-shot boot remap. The remap exchanges the boot ROM window and the main RAM window. RAM moves to the address where ROM sat. ROM moves to just above the end of the RAM window. Afterwards the new bases are driven on dedicated outputs, so the address decoder can use them.

The slave window settings arrive as a packed input vector, one 32-bit word per slave. In each word, bits 31:20 hold the base in megabyte units and bits 19:16 hold a size code, where code k means 2^k megabytes. Software reaches the block through a single-cycle access port with a select, a write enable, an address, four byte enables, write data, registered read data and a registered error flag. Only full-word accesses are legal.

The remap state is sticky. Software cannot undo it, and only reset returns the block to boot mapping.

Top module: `boot_remap_ctl`

## Requirements
- R1: After reset, `remapped` is 0, the control register reads 0, `romBase` equals bits 31:20 of the ROM slave word (slave 4) with 20 zero bits below, and `ramBase` is formed the same way from the RAM slave word (slave 6).
- R2: The revision word at offset 0x8C always reads 0x00010301, and writes to it have no effect. The priority word at 0x80 and the idle word at 0x84 read 0 without error.
- R3: A read of slave offset n*4 (n not 4 or 6) returns slave word n unchanged. A write to any slave offset raises no error and has no effect on later reads.
- R4: A legal write to the control register (offset 0x88) with bit 0 set while not remapped sets `remapped`. It sets `ramBase` to bits 31:20 of the ROM slave word, and `romBase` to the new `ramBase` plus 2^k MB, where k is bits 19:16 of the RAM slave word.
- R5: A read of offset 0x10 returns `romBase` ORed with bits 19:16 of the ROM slave word. A read of offset 0x18 returns `ramBase` ORed with bits 19:16 of the RAM slave word.
- R6: While remapped, a control write with bit 0 clear raises the error flag, leaves `remapped` at 1, and leaves the control register unchanged.
- R7: The control register reads back the last accepted write value, with bit 0 forced to 1 while remapped.
- R8: An access whose byte enables are not all ones raises the error flag, returns 0, and changes no state.
- R9: An access to a misaligned address or to an offset at or above 0x90 returns 0 and raises the error flag.
- R10: Read data and the error flag for an access are valid in the cycle after the access is presented, and a write returns read data 0.
- R11: Before remap, `romBase` and `ramBase` follow changes of the slave words combinationally.
- R12: Once remapped, neither later changes of the slave words nor further control writes with bit 0 set move `romBase` or `ramBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Access strobe, one cycle per access |
| regWrEn | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W (12) | Byte offset of the access |
| regBe | input | 4 | Byte enables; all four must be set |
| regWdata | input | 32 | Write data |
| slaveCfg | input | NUM_SLAVES*32 (1024) | Slave window words, slave n in bits n*32+31 down to n*32 |
| regRdata | output | 32 | Read data of the previous cycle's access |
| regErr | output | 1 | Error for the previous cycle's access |
| romBase | output | 32 | Current ROM window base |
| ramBase | output | 32 | Current RAM window base |
| remapped | output | 1 | Remap has been performed |

## Verification
Read data and the error flag are due on the first clock edge after the cycle in which `regSel` is seen. The scoreboard marks an access as pending when it is driven, and compares it at the falling edge that follows that capture edge. `remapped` and the relocated bases change on that same capture edge, so the bench checks them once the access task has returned. Before remap the bases follow `slaveCfg` with no clock at all, and the bench checks them at the next falling edge after it changes a slave word.

// File: rtl/brm_pkg.sv
package brm_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BASE_LSB = 20;
  localparam int unsigned SIZE_LSB = 16;
  localparam int unsigned SIZE_W   = 4;
  localparam int unsigned IDX_W    = 5;

  localparam logic [7:0] OFS_PRIO = 8'h80;
  localparam logic [7:0] OFS_IDLE = 8'h84;
  localparam logic [7:0] OFS_CTRL = 8'h88;
  localparam logic [7:0] OFS_REV  = 8'h8C;

  localparam logic [WORD_W-1:0] SIZE_FIELD_MASK = 32'h000F_0000;

  typedef enum logic [2:0] {
    ACC_SLAVE,
    ACC_PRIO,
    ACC_IDLE,
    ACC_CTRL,
    ACC_REV,
    ACC_BAD
  } accKind_e;

  // Strobes from control to datapath, valid in the access cycle
  typedef struct packed {
    logic             loadRemap;
    logic             loadCtrl;
    logic             rdValid;
    logic             clrRd;
    accKind_e         kind;
    logic [IDX_W-1:0] slvIdx;
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] baseOf(input logic [WORD_W-1:0] cfg);
    return {cfg[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/brm_ctrl.sv
module brm_ctrl
  import brm_pkg::*;
#(
  parameter int unsigned NUM_SLAVES = 32,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regBe,
  input  logic              wrRemapBit,
  output dpStrobe_t         strobe,
  output logic              remapped,
  output logic              regErr
);

  localparam logic [ADDR_W-1:0] SLAVE_END = ADDR_W'(NUM_SLAVES * 4);

  accKind_e kind;
  logic     aligned;
  logic     fullWord;
  logic     accessOk;
  logic     isCtrlWr;
  logic     badClear;
  logic     errNext;

  always_comb begin
    aligned  = (regAddr[1:0] == 2'b00);
    fullWord = &regBe;
    if (!aligned) begin
      kind = ACC_BAD;
    end else if (regAddr < SLAVE_END) begin
      kind = ACC_SLAVE;
    end else if (regAddr == ADDR_W'(OFS_PRIO)) begin
      kind = ACC_PRIO;
    end else if (regAddr == ADDR_W'(OFS_IDLE)) begin
      kind = ACC_IDLE;
    end else if (regAddr == ADDR_W'(OFS_CTRL)) begin
      kind = ACC_CTRL;
    end else if (regAddr == ADDR_W'(OFS_REV)) begin
      kind = ACC_REV;
    end else begin
      kind = ACC_BAD;
    end
  end

  always_comb begin
    accessOk = regSel && fullWord && (kind != ACC_BAD);
    isCtrlWr = accessOk && regWrEn && (kind == ACC_CTRL);
    badClear = isCtrlWr && remapped && !wrRemapBit;
    errNext  = regSel && (!accessOk || badClear);

    strobe.loadRemap = isCtrlWr && wrRemapBit && !remapped;
    strobe.loadCtrl  = isCtrlWr && !badClear;
    strobe.rdValid   = accessOk && !regWrEn;
    strobe.clrRd     = regSel && !(accessOk && !regWrEn);
    strobe.kind      = kind;
    strobe.slvIdx    = IDX_W'(regAddr >> 2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remapped <= 1'b0;
      regErr   <= 1'b0;
    end else begin
      remapped <= remapped | strobe.loadRemap;
      regErr   <= errNext;
    end
  end

  // R6: remap is one-way until reset
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    remapped |=> remapped);

  // R6: clearing the enable after remap is flagged
  p_bad_clear_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrEn && &regBe && regAddr == ADDR_W'(OFS_CTRL)
     && remapped && !wrRemapBit) |=> regErr);

  // R8: partial-word access is always an error
  p_partial_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !(&regBe)) |=> regErr);

  // R8: partial-word access never triggers remap
  p_partial_no_remap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !(&regBe) && !remapped) |=> !remapped);

endmodule

// File: rtl/brm_datapath.sv
module brm_datapath
  import brm_pkg::*;
#(
  parameter int unsigned       NUM_SLAVES = 32,
  parameter int unsigned       ROM_SLAVE  = 4,
  parameter int unsigned       RAM_SLAVE  = 6,
  parameter logic [31:0]       REV_CODE   = 32'h0001_0301
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic                         remapped,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [NUM_SLAVES*WORD_W-1:0] slaveCfg,
  output logic [WORD_W-1:0]            romBase,
  output logic [WORD_W-1:0]            ramBase,
  output logic [WORD_W-1:0]            regRdata
);

  logic [WORD_W-1:0] cfgWord [NUM_SLAVES];

  for (genvar n = 0; n < NUM_SLAVES; n++) begin : g_cfg
    assign cfgWord[n] = slaveCfg[n*WORD_W +: WORD_W];
  end

  logic [WORD_W-1:0] romCfg;
  logic [WORD_W-1:0] ramCfg;
  logic [WORD_W-1:0] newRamBase;
  logic [WORD_W-1:0] newRomBase;
  logic [5:0]        sizeShift;
  logic [WORD_W-1:0] romBaseReg;
  logic [WORD_W-1:0] ramBaseReg;
  logic [WORD_W-1:0] ctrlReg;
  logic [WORD_W-1:0] readMux;

  assign romCfg = cfgWord[ROM_SLAVE];
  assign ramCfg = cfgWord[RAM_SLAVE];

  always_comb begin
    sizeShift  = 6'(ramCfg[SIZE_LSB +: SIZE_W]) + 6'(BASE_LSB);
    newRamBase = baseOf(romCfg);
    newRomBase = newRamBase + (32'd1 << sizeShift);
  end

  assign romBase = remapped ? romBaseReg : baseOf(romCfg);
  assign ramBase = remapped ? ramBaseReg : baseOf(ramCfg);

  always_comb begin
    unique case (strobe.kind)
      ACC_SLAVE: begin
        if (strobe.slvIdx == IDX_W'(ROM_SLAVE)) begin
          readMux = romBase | (romCfg & SIZE_FIELD_MASK);
        end else if (strobe.slvIdx == IDX_W'(RAM_SLAVE)) begin
          readMux = ramBase | (ramCfg & SIZE_FIELD_MASK);
        end else begin
          readMux = cfgWord[strobe.slvIdx];
        end
      end
      ACC_CTRL: readMux = ctrlReg | {{(WORD_W-1){1'b0}}, remapped};
      ACC_REV:  readMux = REV_CODE;
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romBaseReg <= '0;
      ramBaseReg <= '0;
      ctrlReg    <= '0;
      regRdata   <= '0;
    end else begin
      if (strobe.loadRemap) begin
        ramBaseReg <= newRamBase;
        romBaseReg <= newRomBase;
      end
      if (strobe.loadCtrl) begin
        ctrlReg <= wrData;
      end
      if (strobe.rdValid) begin
        regRdata <= readMux;
      end else if (strobe.clrRd) begin
        regRdata <= '0;
      end
    end
  end

  // R4: relocated RAM base is the old ROM base field
  p_remap_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRemap |=> (remapped &&
      ramBase == {$past(romCfg[WORD_W-1:BASE_LSB]), {BASE_LSB{1'b0}}}));

  // R12: stored bases stay put once remapped
  p_frozen_bases_r12: assert property (@(posedge clk) disable iff (!rstN)
    remapped |=> ($stable(romBase) && $stable(ramBase)));

endmodule

// File: rtl/boot_remap_ctl.sv
module boot_remap_ctl
  import brm_pkg::*;
#(
  parameter int unsigned NUM_SLAVES = 32,
  parameter int unsigned ROM_SLAVE  = 4,
  parameter int unsigned RAM_SLAVE  = 6,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [31:0] REV_CODE   = 32'h0001_0301
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regSel,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [3:0]                   regBe,
  input  logic [WORD_W-1:0]            regWdata,
  input  logic [NUM_SLAVES*WORD_W-1:0] slaveCfg,
  output logic [WORD_W-1:0]            regRdata,
  output logic                         regErr,
  output logic [WORD_W-1:0]            romBase,
  output logic [WORD_W-1:0]            ramBase,
  output logic                         remapped
);

  dpStrobe_t strobe;

  brm_ctrl #(
    .NUM_SLAVES(NUM_SLAVES),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regBe     (regBe),
    .wrRemapBit(regWdata[0]),
    .strobe    (strobe),
    .remapped  (remapped),
    .regErr    (regErr)
  );

  brm_datapath #(
    .NUM_SLAVES(NUM_SLAVES),
    .ROM_SLAVE (ROM_SLAVE),
    .RAM_SLAVE (RAM_SLAVE),
    .REV_CODE  (REV_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .remapped(remapped),
    .wrData  (regWdata),
    .slaveCfg(slaveCfg),
    .romBase (romBase),
    .ramBase (ramBase),
    .regRdata(regRdata)
  );

  // R9: an errored access never returns data
  p_err_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> (regRdata == '0));

  // R10: a write returns zero read data on the next cycle
  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrEn) |=> (regRdata == '0));

endmodule

// File: tb/boot_remap_ctl_tb.sv
`timescale 1ns/1ps
module boot_remap_ctl_tb;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    string       tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regSel = 1'b0;
  logic          regWrEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [3:0]    regBe = '0;
  logic [31:0]   regWdata = '0;
  logic [1023:0] slaveCfg;
  logic [31:0]   regRdata;
  logic          regErr;
  logic [31:0]   romBase;
  logic [31:0]   ramBase;
  logic          remapped;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];
  bit pending = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_remap_ctl u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regAddr(regAddr), .regBe(regBe), .regWdata(regWdata),
    .slaveCfg(slaveCfg), .regRdata(regRdata), .regErr(regErr),
    .romBase(romBase), .ramBase(ramBase), .remapped(remapped)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgOf(input int n);
    return slaveCfg[n*32 +: 32];
  endfunction

  function automatic logic [31:0] topBase(input logic [31:0] w);
    return {w[31:20], 20'h0};
  endfunction

  // driver: one access, expectation pushed to the scoreboard
  task automatic access(input logic [11:0] a, input logic wr, input logic [31:0] d,
                        input logic [3:0] be, input logic [31:0] expRd,
                        input logic expErr, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    regSel = 1'b1; regWrEn = wr; regAddr = a; regWdata = d; regBe = be;
    it.rd = expRd; it.err = expErr; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    regSel = 1'b0; regWrEn = 1'b0; regBe = 4'h0;
  endtask

  // monitor: results are due one edge after the access (R10)
  always @(negedge clk) begin
    if (pending) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 scoreboard empty", 32'h0, 32'h1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(regRdata === it.rd, {it.tag, " R10 rdata"}, regRdata, it.rd);
        check(regErr === it.err, {it.tag, " R10 err"}, {31'h0, regErr}, {31'h0, it.err});
      end
    end
    pending = regSel;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] expRam;
    logic [31:0] expRom;
    logic [31:0] oldRom;
    logic [31:0] oldRam;

    for (int n = 0; n < 32; n++) begin
      slaveCfg[n*32 +: 32] = {12'h800 + 12'(n * 8), 4'(n), 16'h0};
    end
    slaveCfg[4*32 +: 32] = 32'h0003_0000;
    slaveCfg[6*32 +: 32] = 32'h1005_0000;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(remapped === 1'b0, "R1 remapped", {31'h0, remapped}, 32'h0);
    check(romBase === 32'h0000_0000, "R1 romBase", romBase, 32'h0);
    check(ramBase === 32'h1000_0000, "R1 ramBase", ramBase, 32'h1000_0000);
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, "R1 ctrl read");

    // R2 fixed registers
    access(12'h08C, 1'b0, 32'h0, 4'hF, 32'h0001_0301, 1'b0, "R2 rev read");
    access(12'h080, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, "R2 prio read");
    access(12'h084, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, "R2 idle read");
    access(12'h08C, 1'b1, 32'hDEAD_BEEF, 4'hF, 32'h0, 1'b0, "R2 rev write");
    access(12'h08C, 1'b0, 32'h0, 4'hF, 32'h0001_0301, 1'b0, "R2 rev reread");

    // R3 plain slave words
    access(12'h000, 1'b0, 32'h0, 4'hF, cfgOf(0), 1'b0, "R3 slave0");
    access(12'h024, 1'b0, 32'h0, 4'hF, cfgOf(9), 1'b0, "R3 slave9");
    access(12'h07C, 1'b0, 32'h0, 4'hF, cfgOf(31), 1'b0, "R3 slave31");
    access(12'h024, 1'b1, 32'h1234_5678, 4'hF, 32'h0, 1'b0, "R3 slave9 write");
    access(12'h024, 1'b0, 32'h0, 4'hF, cfgOf(9), 1'b0, "R3 slave9 reread");

    // R5 before remap
    access(12'h010, 1'b0, 32'h0, 4'hF, 32'h0003_0000, 1'b0, "R5 rom word pre");
    access(12'h018, 1'b0, 32'h0, 4'hF, 32'h1005_0000, 1'b0, "R5 ram word pre");

    // R11 live tracking before remap
    slaveCfg[4*32 +: 32] = 32'h2003_0000;
    @(negedge clk);
    check(romBase === 32'h2000_0000, "R11 romBase follows", romBase, 32'h2000_0000);
    access(12'h010, 1'b0, 32'h0, 4'hF, 32'h2003_0000, 1'b0, "R11 rom word");

    // R8 partial word
    access(12'h088, 1'b1, 32'h1, 4'h7, 32'h0, 1'b1, "R8 partial ctrl write");
    check(remapped === 1'b0, "R8 no remap", {31'h0, remapped}, 32'h0);
    access(12'h08C, 1'b0, 32'h0, 4'h3, 32'h0, 1'b1, "R8 partial rev read");
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, "R8 ctrl untouched");

    // R9 undefined offsets
    access(12'h090, 1'b0, 32'h0, 4'hF, 32'h0, 1'b1, "R9 offset 0x90");
    access(12'h002, 1'b0, 32'h0, 4'hF, 32'h0, 1'b1, "R9 misaligned");
    access(12'hFFC, 1'b0, 32'h0, 4'hF, 32'h0, 1'b1, "R9 offset 0xFFC");

    // R4 remap
    expRam = topBase(cfgOf(4));
    expRom = expRam + (32'd1 << (cfgOf(6)[19:16] + 20));
    access(12'h088, 1'b1, 32'h0000_00A1, 4'hF, 32'h0, 1'b0, "R4 remap write");
    check(remapped === 1'b1, "R4 remapped", {31'h0, remapped}, 32'h1);
    check(ramBase === expRam, "R4 ramBase", ramBase, expRam);
    check(romBase === expRom, "R4 romBase", romBase, expRom);

    // R5 after remap
    access(12'h010, 1'b0, 32'h0, 4'hF, expRom | 32'h0003_0000, 1'b0, "R5 rom word post");
    access(12'h018, 1'b0, 32'h0, 4'hF, expRam | 32'h0005_0000, 1'b0, "R5 ram word post");

    // R7 control readback
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0000_00A1, 1'b0, "R7 ctrl read");
    access(12'h088, 1'b1, 32'h0000_0003, 4'hF, 32'h0, 1'b0, "R7 ctrl rewrite");
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0000_0003, 1'b0, "R7 ctrl reread");

    // R6 illegal clear
    access(12'h088, 1'b1, 32'h0000_0002, 4'hF, 32'h0, 1'b1, "R6 clear attempt");
    check(remapped === 1'b1, "R6 still remapped", {31'h0, remapped}, 32'h1);
    check(ramBase === expRam, "R6 ramBase kept", ramBase, expRam);
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0000_0003, 1'b0, "R6 ctrl unchanged");

    // R12 frozen after remap
    oldRom = romBase;
    oldRam = ramBase;
    slaveCfg[4*32 +: 32] = 32'h4002_0000;
    slaveCfg[6*32 +: 32] = 32'h5001_0000;
    @(negedge clk);
    check(romBase === oldRom, "R12 romBase frozen", romBase, oldRom);
    check(ramBase === oldRam, "R12 ramBase frozen", ramBase, oldRam);
    access(12'h088, 1'b1, 32'h0000_0001, 4'hF, 32'h0, 1'b0, "R12 second set");
    check(romBase === oldRom, "R12 romBase after set", romBase, oldRom);
    check(ramBase === oldRam, "R12 ramBase after set", ramBase, oldRam);

    // R1 reset after remap
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(remapped === 1'b0, "R1 remapped cleared", {31'h0, remapped}, 32'h0);
    check(romBase === 32'h4000_0000, "R1 romBase restored", romBase, 32'h4000_0000);
    check(ramBase === 32'h5000_0000, "R1 ramBase restored", ramBase, 32'h5000_0000);
    access(12'h088, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, "R1 ctrl cleared");

    repeat (3) @(posedge clk);
    check(expQ.size() == 0, "R10 scoreboard drained", expQ.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule